// File: doc/BRIEF.md
# Cross-Clock Mailbox Pair

This block carries two single-word messages in opposite directions between two ports, A and B, whose clocks are unrelated. The A-to-B mailbox is loaded from port A and consumed on port B. The B-to-A mailbox is loaded from port B and consumed on port A. Each mailbox has an active-low flag. The flag goes low when a word is deposited and returns high once the other side has read it. A new deposit is refused while the flag is low, so an unread word is never overwritten.

Each port has one access strobe, a direction bit and a mailbox-select bit. With the select high, the access goes to a mailbox. With it low, the access belongs to a neighbouring FIFO path. That path is not part of this block, and its output word arrives here as an input. The same select bit also picks what the port shows on its data output: the mailbox it reads from, or the FIFO word.

Each flag is built from two toggle bits. The writer flips a request bit and the reader flips an acknowledge bit. Each side sees the other's bit through a two-flop synchronizer. The data register lives in the writer's clock domain and stays frozen while a message is outstanding, so the reader can sample it safely. Every flag is presented in both clock domains.

Top module: `mbx_pair`

## Requirements
- R1: While rst_ni is low, all four flag outputs are high and both mailbox data registers are cleared to zero, so a port whose select is high outputs zero.
- R2: a_dout_o equals the B-to-A mailbox contents when a_mb_i is high and equals a_fifo_i when a_mb_i is low. b_dout_o does the same with the A-to-B mailbox and b_fifo_i.
- R3: A deposit into the A-to-B mailbox needs a port A rising edge with a_en_i=1, a_wr_i=1 (1 means write, 0 means read), a_mb_i=1 and a_ab_flag_n_o high. That edge stores a_din_i and drives a_ab_flag_n_o low. b_ab_flag_n_o goes low on the second port B edge that follows.
- R4: While a_ab_flag_n_o is low, a write to the A-to-B mailbox is refused: the stored word and both flags are unchanged.
- R5: A read of the A-to-B mailbox needs a port B rising edge with b_en_i=1, b_wr_i=0, b_mb_i=1 and b_ab_flag_n_o low. That edge drives b_ab_flag_n_o high. a_ab_flag_n_o returns high on the second port A edge that follows.
- R6: The B-to-A mailbox obeys R3 to R5 with the two ports exchanged: port B writes through b_ba_flag_n_o and port A reads through a_ba_flag_n_o.
- R7: A mailbox read while the reader-side flag is high returns the stale stored word and changes no flag.
- R8: An access with the select bit low, or with the enable low, leaves both mailboxes and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock, unrelated to clk_a_i |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| a_en_i | input | 1 | Port A access strobe |
| a_wr_i | input | 1 | Port A direction, 1 write, 0 read |
| a_mb_i | input | 1 | Port A mailbox select |
| a_din_i | input | DW | Port A write data |
| a_fifo_i | input | DW | FIFO output word for port A |
| a_dout_o | output | DW | Port A read data |
| a_ab_flag_n_o | output | 1 | A-to-B flag in A domain, low means occupied |
| a_ba_flag_n_o | output | 1 | B-to-A flag in A domain, low means occupied |
| b_en_i | input | 1 | Port B access strobe |
| b_wr_i | input | 1 | Port B direction, 1 write, 0 read |
| b_mb_i | input | 1 | Port B mailbox select |
| b_din_i | input | DW | Port B write data |
| b_fifo_i | input | DW | FIFO output word for port B |
| b_dout_o | output | DW | Port B read data |
| b_ab_flag_n_o | output | 1 | A-to-B flag in B domain, low means occupied |
| b_ba_flag_n_o | output | 1 | B-to-A flag in B domain, low means occupied |

## Verification
The collision that matters is a read on one port landing in the same window as a deposit attempt on the other. For example, port B acknowledges the A-to-B word while port A keeps retrying a write, and that write must stay blocked until the acknowledge has crossed back. Both ports drive dense, independent mailbox and FIFO traffic on clocks whose edges never coincide, so such overlaps happen many times. A behavioural model counts deposits and reads per mailbox, delays each count by two edges of the opposite clock, and compares every flag and output on every edge of both clocks.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  parameter int unsigned MBX_DW   = 32;
  parameter int unsigned MBX_SYNC = 2;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } mbx_op_e;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned DW   = 32,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_w_i,
  input  logic          clk_r_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_req_i,
  output logic [DW-1:0] data_o,
  output logic          flag_w_o,
  output logic          flag_r_o
);
  logic          set_q, ack_q;
  logic          set_r, ack_w;
  logic [DW-1:0] data_q;
  logic          wr_fire, rd_fire;

  // writer domain
  assign flag_w_o = (set_q == ack_w);
  assign wr_fire  = wr_req_i & flag_w_o;

  always_ff @(posedge clk_w_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q  <= 1'b0;
      data_q <= '0;
    end else if (wr_fire) begin
      set_q  <= ~set_q;
      data_q <= wr_data_i;
    end
  end

  mbx_sync #(.STAGES(SYNC)) u_ack_sync (
    .clk_i (clk_w_i),
    .rst_ni(rst_ni),
    .d_i   (ack_q),
    .q_o   (ack_w)
  );

  // reader domain
  mbx_sync #(.STAGES(SYNC)) u_set_sync (
    .clk_i (clk_r_i),
    .rst_ni(rst_ni),
    .d_i   (set_q),
    .q_o   (set_r)
  );

  assign flag_r_o = (set_r == ack_q);
  assign rd_fire  = rd_req_i & ~flag_r_o;

  always_ff @(posedge clk_r_i or negedge rst_ni) begin
    if (!rst_ni)      ack_q <= 1'b0;
    else if (rd_fire) ack_q <= ~ack_q;
  end

  // data_q frozen while a message is outstanding
  assign data_o = data_q;

  AST_WR_DROPS_FLAG: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    wr_fire |=> !flag_w_o); // R3
  AST_BLOCKED_KEEPS_DATA: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    (wr_req_i && !flag_w_o) |=> $stable(data_q)); // R4
  AST_NO_REQ_KEEPS_DATA: assert property (@(posedge clk_w_i) disable iff (!rst_ni)
    !wr_req_i |=> $stable(data_q)); // R8
  AST_RD_RAISES_FLAG: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    rd_fire |=> flag_r_o); // R5
  AST_STALE_READ_QUIET: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (rd_req_i && flag_r_o) |=> $stable(ack_q)); // R7
  AST_READER_FLAG_HOLDS: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (!flag_r_o && !rd_req_i) |=> !flag_r_o); // R5
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int unsigned DW   = MBX_DW,
  parameter int unsigned SYNC = MBX_SYNC
) (
  input  logic          clk_a_i,
  input  logic          clk_b_i,
  input  logic          rst_ni,
  input  logic          a_en_i,
  input  logic          a_wr_i,
  input  logic          a_mb_i,
  input  logic [DW-1:0] a_din_i,
  input  logic [DW-1:0] a_fifo_i,
  output logic [DW-1:0] a_dout_o,
  output logic          a_ab_flag_n_o,
  output logic          a_ba_flag_n_o,
  input  logic          b_en_i,
  input  logic          b_wr_i,
  input  logic          b_mb_i,
  input  logic [DW-1:0] b_din_i,
  input  logic [DW-1:0] b_fifo_i,
  output logic [DW-1:0] b_dout_o,
  output logic          b_ab_flag_n_o,
  output logic          b_ba_flag_n_o
);
  localparam int unsigned NCH = 2;  // 0: A->B, 1: B->A

  logic a_wr_req, a_rd_req, b_wr_req, b_rd_req;
  logic [NCH-1:0]         clk_w, clk_r, wr_req, rd_req, flag_w, flag_r;
  logic [NCH-1:0][DW-1:0] wr_data, mbx_data;

  assign a_wr_req = a_en_i & a_mb_i & (mbx_op_e'(a_wr_i) == OP_WRITE);
  assign a_rd_req = a_en_i & a_mb_i & (mbx_op_e'(a_wr_i) == OP_READ);
  assign b_wr_req = b_en_i & b_mb_i & (mbx_op_e'(b_wr_i) == OP_WRITE);
  assign b_rd_req = b_en_i & b_mb_i & (mbx_op_e'(b_wr_i) == OP_READ);

  assign clk_w   = {clk_b_i, clk_a_i};
  assign clk_r   = {clk_a_i, clk_b_i};
  assign wr_req  = {b_wr_req, a_wr_req};
  assign rd_req  = {a_rd_req, b_rd_req};
  assign wr_data = {b_din_i, a_din_i};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    mbx_channel #(.DW(DW), .SYNC(SYNC)) u_chan (
      .clk_w_i  (clk_w[ch]),
      .clk_r_i  (clk_r[ch]),
      .rst_ni   (rst_ni),
      .wr_req_i (wr_req[ch]),
      .wr_data_i(wr_data[ch]),
      .rd_req_i (rd_req[ch]),
      .data_o   (mbx_data[ch]),
      .flag_w_o (flag_w[ch]),
      .flag_r_o (flag_r[ch])
    );
  end

  assign a_ab_flag_n_o = flag_w[0];
  assign b_ab_flag_n_o = flag_r[0];
  assign b_ba_flag_n_o = flag_w[1];
  assign a_ba_flag_n_o = flag_r[1];

  // shared output mux: mailbox vs FIFO word
  assign a_dout_o = a_mb_i ? mbx_data[1] : a_fifo_i;
  assign b_dout_o = b_mb_i ? mbx_data[0] : b_fifo_i;

  AST_RST_FLAGS_A: assert property (@(posedge clk_a_i)
    !rst_ni |-> (a_ab_flag_n_o && a_ba_flag_n_o)); // R1
  AST_RST_FLAGS_B: assert property (@(posedge clk_b_i)
    !rst_ni |-> (b_ab_flag_n_o && b_ba_flag_n_o)); // R1
  AST_FIFO_PATH_A: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !a_mb_i |-> (a_dout_o == a_fifo_i)); // R2
endmodule

// File: tb/mbx_pair_test.sv
`timescale 1ns/100ps
module mbx_pair_test;
  localparam int DW = 32;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_ni = 1'b0;
  logic a_en = 0, a_wr = 0, a_mb = 0, b_en = 0, b_wr = 0, b_mb = 0;
  logic [DW-1:0] a_din = '0, a_fifo = '0, b_din = '0, b_fifo = '0;
  logic [DW-1:0] a_dout, b_dout;
  logic a_ab_fl, a_ba_fl, b_ab_fl, b_ba_fl;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // model: per-mailbox deposit/read counts, each seen through two edges of the other clock
  int ab_wr = 0, ab_rd = 0, ab_s1 = 0, ab_s2 = 0, ab_k1 = 0, ab_k2 = 0;
  int ba_wr = 0, ba_rd = 0, ba_s1 = 0, ba_s2 = 0, ba_k1 = 0, ba_k2 = 0;
  logic [DW-1:0] ab_data = '0, ba_data = '0;

  mbx_pair #(.DW(DW)) uut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_ni),
    .a_en_i(a_en), .a_wr_i(a_wr), .a_mb_i(a_mb), .a_din_i(a_din), .a_fifo_i(a_fifo),
    .a_dout_o(a_dout), .a_ab_flag_n_o(a_ab_fl), .a_ba_flag_n_o(a_ba_fl),
    .b_en_i(b_en), .b_wr_i(b_wr), .b_mb_i(b_mb), .b_din_i(b_din), .b_fifo_i(b_fifo),
    .b_dout_o(b_dout), .b_ab_flag_n_o(b_ab_fl), .b_ba_flag_n_o(b_ba_fl)
  );

  always #2 clk_a = ~clk_a;                     // 250 MHz, rises at 2+4k
  initial begin #0.5; forever #3 clk_b = ~clk_b; end  // rises at 3.5+6k

  task automatic check(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, got, exp);
    end
  endtask

  // port A edge
  always begin
    @(posedge clk_a);
    if (rst_ni) begin
      bit ab_free, ba_full;
      ab_free = (ab_wr == ab_k2);
      ba_full = (ba_s2 != ba_rd);
      // R4: blocked write; R8: select or enable low ignored
      if (a_en && a_wr && a_mb && ab_free) begin ab_data = a_din; ab_wr++; end
      // R7: read with no message changes nothing
      if (a_en && !a_wr && a_mb && ba_full) ba_rd++;
      ab_k2 = ab_k1; ab_k1 = ab_rd;
      ba_s2 = ba_s1; ba_s1 = ba_wr;
    end
    #1;
    if (!rst_ni) begin
      check("R1", {31'd0, a_ab_fl}, 1);
      check("R1", {31'd0, a_ba_fl}, 1);
    end
    check("R3", {31'd0, a_ab_fl}, (ab_wr == ab_k2));
    check("R6", {31'd0, a_ba_fl}, (ba_s2 == ba_rd));
    check("R2", a_dout, a_mb ? ba_data : a_fifo);
  end

  // port B edge
  always begin
    @(posedge clk_b);
    if (rst_ni) begin
      bit ba_free, ab_full;
      ba_free = (ba_wr == ba_k2);
      ab_full = (ab_s2 != ab_rd);
      if (b_en && b_wr && b_mb && ba_free) begin ba_data = b_din; ba_wr++; end
      if (b_en && !b_wr && b_mb && ab_full) ab_rd++;
      ba_k2 = ba_k1; ba_k1 = ba_rd;
      ab_s2 = ab_s1; ab_s1 = ab_wr;
    end
    #1;
    if (!rst_ni) begin
      check("R1", {31'd0, b_ab_fl}, 1);
      check("R1", {31'd0, b_ba_fl}, 1);
      if (b_mb) check("R1", b_dout, '0);
    end
    check("R5", {31'd0, b_ab_fl}, (ab_s2 == ab_rd));
    check("R6", {31'd0, b_ba_fl}, (ba_wr == ba_k2));
    check("R2", b_dout, b_mb ? ab_data : b_fifo);
  end

  task automatic drive_a(bit en, bit wr, bit mb, logic [DW-1:0] d);
    @(negedge clk_a);
    a_en = en; a_wr = wr; a_mb = mb; a_din = d; a_fifo = $urandom;
  endtask

  task automatic drive_b(bit en, bit wr, bit mb, logic [DW-1:0] d);
    @(negedge clk_b);
    b_en = en; b_wr = wr; b_mb = mb; b_din = d; b_fifo = $urandom;
  endtask

  initial begin
    b_mb = 1'b1;
    a_fifo = 32'h0bad_f00d;
    #20.7 rst_ni = 1'b1;
    fork
      begin
        drive_a(1, 1, 1, 32'h1111_0001);           // R3 deposit
        drive_a(1, 1, 1, 32'h2222_0002);           // R4 refused
        drive_a(1, 1, 0, 32'h3333_0003);           // R8 FIFO-directed
        drive_a(0, 1, 1, 32'h4444_0004);           // R8 disabled
        drive_a(1, 0, 1, '0);                      // R7 stale read of B-to-A
        repeat (20) drive_a(0, 0, 1, '0);
        for (int i = 0; i < 3000; i++)
          drive_a(($urandom % 10) < 7, $urandom % 2, ($urandom % 10) < 7, $urandom);
        drive_a(0, 0, 0, '0);
      end
      begin
        repeat (6) drive_b(0, 0, 1, '0);
        drive_b(1, 0, 1, '0);                      // R5 read A-to-B
        drive_b(1, 0, 1, '0);                      // R7 stale read
        drive_b(1, 1, 1, 32'h5555_0005);           // R6 deposit B-to-A
        repeat (12) drive_b(0, 0, 1, '0);
        for (int i = 0; i < 2000; i++)
          drive_b(($urandom % 10) < 7, $urandom % 2, ($urandom % 10) < 7, $urandom);
        drive_b(0, 0, 0, '0);
      end
    join
    repeat (4) @(negedge clk_b);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule